// File: doc/BRIEF.md
# Parallel Printer Port Register Block

This block is the host side of a standard byte-wide parallel printer port. It has three byte registers: a data latch, a status register and a control register. A single-cycle register bus selects them through the low three address bits. There is no printer pin interface. Instead, the block plays the printer's side of the handshake itself, so a driver that follows the usual strobe, busy and acknowledge protocol can print with no external device present.

A byte counts as printed when the control register sees a strobe edge. That byte then leaves the block as a one-cycle pulse on a valid/byte stream. When the control register selects the reverse direction, the data register reads from a byte input instead. The control write sequence can raise a pending interrupt, and reading the status register clears it. Each status read also advances the emulated busy/acknowledge toggling by one step.

Top module: `pport_regblock`

## Requirements
- R1: `addr` selects the register: 0 is data, 1 is status, 2 is control. A read at offsets 3 to 7 returns 0xFF. A write to offset 1 or to offsets 3 to 7 changes no register, no output and not the interrupt.
- R2: Control bit fields are: bit5 direction (1 = input), bit4 interrupt enable, bit3 select, bit2 init, bit1 auto-linefeed, bit0 strobe. Every control write stores the written value with bits 7:6 forced to 1, and a control read returns that stored value.
- R3: A control write with init (bit2) = 0 loads status with 0xD8: not-busy, acknowledge, online and not-error set, and timeout clear.
- R4: A control write with init = 1, select = 1 and strobe = 1 clears status bit7 (not-busy). If the previously stored control value had strobe = 0, `out_valid` is high for the one cycle after that write's clock edge, with `out_byte` equal to the held data byte.
- R5: A control write with init = 1, select = 1 and strobe = 0 sets the interrupt pending flag when the previously stored control value (not the value being written) had interrupt enable = 1.
- R6: A data read returns `din` when the stored direction bit is 1. Otherwise it returns the last byte written to the data register.
- R7: A status read returns the current status and clears the pending flag. The status bits are: bit7 not-busy, bit6 acknowledge, bit5 paper-out, bit4 online, bit3 not-error, bit0 timeout. If not-busy = 0 and the stored strobe = 0, the read also steps the handshake: a set acknowledge is cleared, and a clear acknowledge sets both acknowledge and not-busy.
- R8: After reset the data latch reads 0xFF, status reads 0xD9, control reads 0xCC, and `irq` and `out_valid` are 0.
- R9: `irq` is a register equal to the pending flag. It changes at the clock edge that ends the access that set or cleared the flag, and a data write does not touch it.
- R10: A control write with init = 1 and select = 0 leaves status, the pending flag and the byte stream unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per access |
| rd_en | input | 1 | Register read strobe, one cycle per access |
| addr | input | 3 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid in the access cycle |
| din | input | 8 | Byte presented by the far side for direction = input |
| out_valid | output | 1 | One-cycle pulse for an emitted byte |
| out_byte | output | 8 | Emitted byte |
| irq | output | 1 | Level interrupt, equals the pending flag |

## Verification
The assertions check every cycle that:
- an emitted byte always traces back to a strobe-rising control write;
- a strobe-high write always leaves not-busy clear;
- an init-low write always loads 0xD8;
- `irq` rises only after a qualifying control write and falls only after a status read;
- unmapped reads return 0xFF and control reads show bits 7:6 set.

Some behaviours only the bench scenarios can show. These are the full busy/acknowledge walk across successive status reads, and the rule that the previous interrupt enable (not the written one) decides whether the pending flag is set. They also include suppression of a repeated strobe-high write, the direction-dependent data read, and recovery of every register after a mid-run reset.

// File: rtl/pport_pkg.sv
package pport_pkg;

  // register offsets
  localparam int OFS_DATA = 0;
  localparam int OFS_STAT = 1;
  localparam int OFS_CTRL = 2;

  // status bit positions
  localparam int ST_NBUSY = 7;
  localparam int ST_ACK   = 6;
  localparam int ST_TMO   = 0;

  // control bit positions
  localparam int CT_DIR  = 5;
  localparam int CT_IEN  = 4;
  localparam int CT_SEL  = 3;
  localparam int CT_INIT = 2;
  localparam int CT_STB  = 0;

  localparam logic [7:0] CTRL_FORCE = 8'hC0;
  localparam logic [7:0] CTRL_RST   = 8'hCC;
  localparam logic [7:0] STAT_RST   = 8'hD9;
  localparam logic [7:0] STAT_INIT  = 8'hD8;
  localparam logic [7:0] DATA_RST   = 8'hFF;
  localparam logic [7:0] UNMAPPED   = 8'hFF;

  // value actually stored on a control write
  function automatic logic [7:0] ctrl_norm(input logic [7:0] v);
    return v | CTRL_FORCE;
  endfunction

  // one emulated handshake step performed by a status read
  function automatic logic [7:0] hs_step(input logic [7:0] st);
    logic [7:0] r;
    r = st;
    if (st[ST_ACK]) begin
      r[ST_ACK] = 1'b0;
    end else begin
      r[ST_ACK]   = 1'b1;
      r[ST_NBUSY] = 1'b1;
    end
    return r;
  endfunction

  // whether a status read advances the handshake
  function automatic logic hs_due(input logic [7:0] st, input logic [7:0] ct);
    return !st[ST_NBUSY] && !ct[CT_STB];
  endfunction

endpackage

// File: rtl/pport_ctrl.sv
module pport_ctrl
  import pport_pkg::*;
#(
  parameter int AW = 3,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] ctrl_q,
  output logic [DW-1:0] dataw_q,
  output logic          ev_init_load,
  output logic          ev_busy_clr,
  output logic          ev_irq_set,
  output logic          out_valid,
  output logic [DW-1:0] out_byte
);

  localparam logic [AW-1:0] A_DATA = AW'(OFS_DATA);
  localparam logic [AW-1:0] A_CTRL = AW'(OFS_CTRL);

  logic          wr_ctrl;
  logic          wr_data;
  logic [DW-1:0] ctrl_nx;
  logic          ev_armed;
  logic          ev_emit;

  assign wr_ctrl  = wr_en && (addr == A_CTRL);
  assign wr_data  = wr_en && (addr == A_DATA);
  assign ctrl_nx  = ctrl_norm(wdata);

  // decoded write events, brought out for the status block and assertions
  assign ev_init_load = wr_ctrl && !ctrl_nx[CT_INIT];
  assign ev_armed     = wr_ctrl && ctrl_nx[CT_INIT] && ctrl_nx[CT_SEL];
  assign ev_busy_clr  = ev_armed && ctrl_nx[CT_STB];
  assign ev_emit      = ev_busy_clr && !ctrl_q[CT_STB];
  assign ev_irq_set   = ev_armed && !ctrl_nx[CT_STB] && ctrl_q[CT_IEN];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= CTRL_RST;
      dataw_q <= DATA_RST;
    end else begin
      if (wr_ctrl) ctrl_q  <= ctrl_nx;
      if (wr_data) dataw_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_byte  <= DATA_RST;
    end else begin
      out_valid <= ev_emit;
      if (ev_emit) out_byte <= dataw_q;
    end
  end

  // R4: an emitted byte comes only from a strobe-high write after strobe low
  assert_emit_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(wr_en && addr == A_CTRL && wdata[CT_STB] && !ctrl_q[CT_STB]));

  // R4: emitted byte is the data latch as held at the write
  assert_emit_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_byte == $past(dataw_q)));

endmodule

// File: rtl/pport_status.sv
module pport_status
  import pport_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_init_load,
  input  logic          ev_busy_clr,
  input  logic          ev_irq_set,
  input  logic          stat_rd,
  input  logic [DW-1:0] ctrl_q,
  output logic [DW-1:0] stat_q,
  output logic          irq
);

  logic          ev_hs_step;
  logic [DW-1:0] stat_nx;

  assign ev_hs_step = stat_rd && hs_due(stat_q, ctrl_q);

  always_comb begin
    stat_nx = stat_q;
    if (ev_init_load) begin
      stat_nx = STAT_INIT;
    end else if (ev_busy_clr) begin
      stat_nx[ST_NBUSY] = 1'b0;
    end else if (ev_hs_step) begin
      stat_nx = hs_step(stat_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= STAT_RST;
      irq    <= 1'b0;
    end else begin
      stat_q <= stat_nx;
      if (stat_rd)         irq <= 1'b0;
      else if (ev_irq_set) irq <= 1'b1;
    end
  end

  // R3: init-low write loads the fixed status value
  assert_init_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_init_load |=> (stat_q == STAT_INIT));

  // R4: strobe-high write leaves not-busy clear
  assert_busy_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_busy_clr |=> !stat_q[ST_NBUSY]);

  // R5 / R9: interrupt rises only after a qualifying control write
  assert_irq_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(ev_irq_set));

  // R7 / R9: interrupt falls only after a status read
  assert_irq_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(stat_rd));

endmodule

// File: rtl/pport_rdmux.sv
module pport_rdmux
  import pport_pkg::*;
#(
  parameter int AW = 3,
  parameter int DW = 8
) (
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] dataw_q,
  input  logic [DW-1:0] stat_q,
  input  logic [DW-1:0] ctrl_q,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] rdata
);

  always_comb begin
    case (int'(addr))
      OFS_DATA: rdata = ctrl_q[CT_DIR] ? din : dataw_q;
      OFS_STAT: rdata = stat_q;
      OFS_CTRL: rdata = ctrl_q;
      default:  rdata = UNMAPPED;
    endcase
  end

endmodule

// File: rtl/pport_regblock.sv
module pport_regblock
  import pport_pkg::*;
#(
  parameter int AW = 3,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [DW-1:0] din,
  output logic          out_valid,
  output logic [DW-1:0] out_byte,
  output logic          irq
);

  localparam logic [AW-1:0] A_STAT = AW'(OFS_STAT);
  localparam logic [AW-1:0] A_CTRL = AW'(OFS_CTRL);
  localparam int            NMAP   = 3;

  logic [DW-1:0] ctrl_q;
  logic [DW-1:0] dataw_q;
  logic [DW-1:0] stat_q;
  logic          ev_init_load;
  logic          ev_busy_clr;
  logic          ev_irq_set;
  logic          stat_rd;

  // a write in the same cycle wins; the read then has no side effect
  assign stat_rd = rd_en && !wr_en && (addr == A_STAT);

  pport_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .addr         (addr),
    .wdata        (wdata),
    .ctrl_q       (ctrl_q),
    .dataw_q      (dataw_q),
    .ev_init_load (ev_init_load),
    .ev_busy_clr  (ev_busy_clr),
    .ev_irq_set   (ev_irq_set),
    .out_valid    (out_valid),
    .out_byte     (out_byte)
  );

  pport_status #(.DW(DW)) u_status (
    .clk          (clk),
    .rst_n        (rst_n),
    .ev_init_load (ev_init_load),
    .ev_busy_clr  (ev_busy_clr),
    .ev_irq_set   (ev_irq_set),
    .stat_rd      (stat_rd),
    .ctrl_q       (ctrl_q),
    .stat_q       (stat_q),
    .irq          (irq)
  );

  pport_rdmux #(.AW(AW), .DW(DW)) u_rdmux (
    .addr    (addr),
    .dataw_q (dataw_q),
    .stat_q  (stat_q),
    .ctrl_q  (ctrl_q),
    .din     (din),
    .rdata   (rdata)
  );

  // R1: offsets past the mapped set read as all ones
  assert_unmapped_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && int'(addr) >= NMAP) |-> (rdata == UNMAPPED));

  // R2: control readback always shows the forced-high bits
  assert_ctrl_hi_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_CTRL) |-> (rdata[7:6] == 2'b11));

endmodule

// File: tb/tb_pport_regblock.sv
`timescale 1ns/1ps
module tb_pport_regblock;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] din = 8'hA5;
  logic [7:0] rdata;
  logic       out_valid;
  logic [7:0] out_byte;
  logic       irq;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  pport_regblock dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .din(din), .out_valid(out_valid),
    .out_byte(out_byte), .irq(irq)
  );

  // entry: {write, addr, data, expected rdata, irq after, out_valid after, req}
  localparam int NV = 31;
  localparam logic [25:0] VEC [NV] = '{
    {1'b0, 3'd2, 8'h00, 8'hCC, 1'b0, 1'b0, 4'd8},  // R8 control reset
    {1'b0, 3'd1, 8'h00, 8'hD9, 1'b0, 1'b0, 4'd8},  // R8 status reset
    {1'b0, 3'd0, 8'h00, 8'hFF, 1'b0, 1'b0, 4'd8},  // R8 data reset
    {1'b0, 3'd5, 8'h00, 8'hFF, 1'b0, 1'b0, 4'd1},  // R1 unmapped
    {1'b1, 3'd0, 8'h41, 8'h00, 1'b0, 1'b0, 4'd1},  // R1 data write
    {1'b0, 3'd0, 8'h00, 8'h41, 1'b0, 1'b0, 4'd6},  // R6 readback, dir out
    {1'b1, 3'd2, 8'h1C, 8'h00, 1'b0, 1'b0, 4'd5},  // R5 old enable was 0
    {1'b0, 3'd2, 8'h00, 8'hDC, 1'b0, 1'b0, 4'd2},  // R2 forced bits
    {1'b1, 3'd2, 8'h1D, 8'h00, 1'b0, 1'b1, 4'd4},  // R4 strobe rises: emit
    {1'b0, 3'd1, 8'h00, 8'h59, 1'b0, 1'b0, 4'd4},  // R4 busy, strobe high: no step
    {1'b1, 3'd2, 8'h1C, 8'h00, 1'b1, 1'b0, 4'd5},  // R5 pending set
    {1'b0, 3'd1, 8'h00, 8'h59, 1'b0, 1'b0, 4'd7},  // R7 clears pending, ack cleared
    {1'b0, 3'd1, 8'h00, 8'h19, 1'b0, 1'b0, 4'd7},  // R7 ack and not-busy set
    {1'b0, 3'd1, 8'h00, 8'hD9, 1'b0, 1'b0, 4'd7},  // R7 idle, no step
    {1'b1, 3'd2, 8'h1D, 8'h00, 1'b0, 1'b1, 4'd4},  // R4 second byte
    {1'b1, 3'd2, 8'h1D, 8'h00, 1'b0, 1'b0, 4'd4},  // R4 repeat strobe high: no emit
    {1'b1, 3'd2, 8'h18, 8'h00, 1'b0, 1'b0, 4'd3},  // R3 init low
    {1'b0, 3'd1, 8'h00, 8'hD8, 1'b0, 1'b0, 4'd3},  // R3 status loaded
    {1'b1, 3'd2, 8'h3C, 8'h00, 1'b1, 1'b0, 4'd5},  // R5 dir in, pending
    {1'b0, 3'd0, 8'h00, 8'hA5, 1'b1, 1'b0, 4'd6},  // R6 input byte
    {1'b1, 3'd0, 8'h77, 8'h00, 1'b1, 1'b0, 4'd9},  // R9 data write keeps irq
    {1'b1, 3'd1, 8'h00, 8'h00, 1'b1, 1'b0, 4'd1},  // R1 status write ignored
    {1'b0, 3'd1, 8'h00, 8'hD8, 1'b0, 1'b0, 4'd1},  // R1 status unchanged
    {1'b1, 3'd2, 8'h0C, 8'h00, 1'b1, 1'b0, 4'd5},  // R5 previous enable decides
    {1'b0, 3'd1, 8'h00, 8'hD8, 1'b0, 1'b0, 4'd7},  // R7 clear
    {1'b1, 3'd2, 8'h0C, 8'h00, 1'b0, 1'b0, 4'd5},  // R5 enable now 0
    {1'b1, 3'd2, 8'h05, 8'h00, 1'b0, 1'b0, 4'd10}, // R10 select low
    {1'b0, 3'd1, 8'h00, 8'hD8, 1'b0, 1'b0, 4'd10}, // R10 status unchanged
    {1'b0, 3'd0, 8'h00, 8'h77, 1'b0, 1'b0, 4'd6},  // R6 dir out again
    {1'b0, 3'd7, 8'h00, 8'hFF, 1'b0, 1'b0, 4'd1},  // R1 unmapped
    {1'b0, 3'd3, 8'h00, 8'hFF, 1'b0, 1'b0, 4'd1}   // R1 unmapped
  };

  task automatic chk(input logic ok, input int req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL R%0d %s actual=%02h expected=%02h", req, what, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [2:0] a, input logic [7:0] d,
                        output logic [7:0] got);
    @(negedge clk);
    wr_en = wr; rd_en = !wr; addr = a; wdata = d;
    #1 got = rdata;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    #1;
  endtask

  logic [7:0] last_data = 8'hFF;
  logic [7:0] got;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      logic [25:0] v;
      int req;
      v = VEC[i];
      req = int'(v[3:0]);
      access(v[25], v[24:22], v[21:14], got);
      if (v[25]) begin
        if (v[24:22] == 3'd0) last_data = v[21:14];
      end else begin
        chk(got == v[13:6], req, "rdata", got, v[13:6]);
      end
      chk(irq == v[5], req, "irq", {7'd0, irq}, {7'd0, v[5]});
      chk(out_valid == v[4], req, "out_valid", {7'd0, out_valid}, {7'd0, v[4]});
      if (v[4]) chk(out_byte == last_data, 4, "out_byte", out_byte, last_data);
    end

    // R9: irq changes only at the edge that ends the setting write
    access(1'b1, 3'd2, 8'h1C, got);          // ctrl DC, old enable 0
    @(negedge clk);
    wr_en = 1'b1; addr = 3'd2; wdata = 8'h1C;
    #1 chk(irq == 1'b0, 9, "irq before edge", {7'd0, irq}, 8'h00);
    @(negedge clk);
    wr_en = 1'b0;
    #1 chk(irq == 1'b1, 9, "irq after edge", {7'd0, irq}, 8'h01);

    // R8: reset in mid-run restores everything
    @(negedge clk);
    rst_n = 1'b0;
    #1 chk(irq == 1'b0, 8, "irq in reset", {7'd0, irq}, 8'h00);
    chk(out_valid == 1'b0, 8, "out_valid in reset", {7'd0, out_valid}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    access(1'b0, 3'd2, 8'h00, got);
    chk(got == 8'hCC, 8, "ctrl after reset", got, 8'hCC);
    access(1'b0, 3'd0, 8'h00, got);
    chk(got == 8'hFF, 8, "data after reset", got, 8'hFF);
    access(1'b0, 3'd1, 8'h00, got);
    chk(got == 8'hD9, 8, "status after reset", got, 8'hD9);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL R9 watchdog actual=%02h expected=%02h", 8'h00, 8'h01);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule